// File: doc/BRIEF.md
# Code-Density Fine-Bin Calibration Engine

This block calibrates the fine interpolator of a delay-line time-to-digital converter. A stream of calibration hits whose timing has no correlation with the converter clock is fed in as fine bin codes. Because these hits are uncorrelated, the number of hits that land in a bin is proportional to that bin's width. The engine keeps one histogram counter per bin and counts hits until a fixed power-of-two total has been accepted. It then walks the histogram once and fills a table holding the calibrated centre time of every bin in picoseconds.

Each bin is measured on its own, so bins of unequal width get their true centre times. No single average cell delay is assumed. Adjacent bins can differ widely, for example when rising and falling edges travel the line at different speeds. Calibration starts on its own after reset and again on every start request. Table lookups are served only once a calibration has completed.

Top module: `tdc_code_density_cal`

## Requirements
- R1: After reset the engine reports busy (`calBusy`=1, `calDone`=0). It first zeroes every histogram bin, one bin per cycle for NUM_BINS cycles, and ignores hits during that time. It then starts collecting.
- R2: While collecting, a hit with `hitValid`=1 and `hitCode` < NUM_BINS adds one to that bin's count. A hit with a code of NUM_BINS or more changes no count and does not count toward the total.
- R3: Collection ends on the cycle that accepts the 2^HIT_LOG2-th in-range hit. Hits that arrive during the table build, or after it, change nothing.
- R4: A bin count never goes above 2^CNT_W-1. Further hits into a full bin leave it at that value.
- R5: The table entry of bin i equals floor((S_i + floor(c_i/2)) * PERIOD_PS / 2^HIT_LOG2). Here c_i is the bin's count and S_i is the sum of the counts of bins 0..i-1.
- R6: The build processes one bin per cycle in ascending order, NUM_BINS cycles in all. `calDone` is high for exactly one cycle, on the cycle after the last bin. `calBusy` falls on that same cycle.
- R7: While idle (`calBusy`=0), a lookup with `lookupValid`=1 produces `lookOk`=1 on the next cycle. `lookTime` then holds the table entry for `lookupAddr`, or 0 if the address is NUM_BINS or more. A lookup made while busy produces no `lookOk`.
- R8: `calStart`=1 in any cycle takes priority over everything else. It discards all counts, makes the engine busy from the next cycle, and repeats the clear, collect and build sequence from the start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous reset, active high |
| calStart | input | 1 | Request a new calibration |
| hitValid | input | 1 | Calibration hit strobe |
| hitCode | input | CODE_W | Fine bin code of the hit |
| lookupValid | input | 1 | Table lookup strobe |
| lookupAddr | input | CODE_W | Bin to look up |
| calBusy | output | 1 | Clearing, collecting or building |
| calDone | output | 1 | One-cycle pulse when the table is complete |
| lookOk | output | 1 | Lookup result valid |
| lookTime | output | TIME_W | Calibrated bin centre in picoseconds |

## Verification
The bench builds the engine with six bins, so a three-bit code can name bins 6 and 7 and the out-of-range path is exercised. It uses a 64-hit total, five-bit counters and a 1000 ps period. With a five-bit counter, one bin saturates at 31 well before the total is reached. The short total means each calibration, including a restart in the middle of collection, finishes within a few hundred cycles. The small bin count lets every table entry be read back and compared against the centre formula after each run.

// File: rtl/tdc_cal_pkg.sv
package tdc_cal_pkg;

  typedef enum logic [1:0] {
    PH_CLEAR   = 2'd0,
    PH_COLLECT = 2'd1,
    PH_BUILD   = 2'd2,
    PH_READY   = 2'd3
  } calPhase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrWr;    // zero histogram entry at walk index
    logic hitEn;    // increment histogram entry at hit code
    logic buildWr;  // write table entry at walk index, advance running sum
    logic sumClr;   // hold running sum at zero
  } calStrobe_t;

endpackage

// File: rtl/tdc_cal_ctrl.sv
module tdc_cal_ctrl
  import tdc_cal_pkg::*;
#(
  parameter int NUM_BINS = 64,
  parameter int HIT_LOG2 = 14,
  localparam int CODE_W = $clog2(NUM_BINS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startReq,
  input  logic              hitValid,
  input  logic              hitInRange,
  output logic [CODE_W-1:0] walkIdx,
  output calStrobe_t        strobe,
  output logic              busy,
  output logic              done,
  output logic              ready
);

  localparam logic [CODE_W-1:0] LAST_IDX = CODE_W'(NUM_BINS - 1);

  calPhase_t            phase;
  logic [HIT_LOG2-1:0]  hitCnt;
  logic                 doneQ;
  logic                 walkLast;
  logic                 hitAccept;

  assign walkLast  = (walkIdx == LAST_IDX);
  assign hitAccept = (phase == PH_COLLECT) && hitValid && hitInRange && !startReq;

  always_comb begin
    strobe = '0;
    unique case (phase)
      PH_CLEAR:   strobe.clrWr   = !startReq;
      PH_COLLECT: begin
        strobe.sumClr = 1'b1;
        strobe.hitEn  = hitAccept;
      end
      PH_BUILD:   strobe.buildWr = !startReq;
      default:    ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_CLEAR;
      walkIdx <= '0;
      hitCnt  <= '0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (startReq) begin
        phase   <= PH_CLEAR;
        walkIdx <= '0;
      end else begin
        unique case (phase)
          PH_CLEAR: begin
            if (walkLast) begin
              phase   <= PH_COLLECT;
              walkIdx <= '0;
              hitCnt  <= '0;
            end else begin
              walkIdx <= walkIdx + 1'b1;
            end
          end
          PH_COLLECT: begin
            if (hitAccept) begin
              if (&hitCnt) begin
                phase   <= PH_BUILD;
                walkIdx <= '0;
              end else begin
                hitCnt <= hitCnt + 1'b1;
              end
            end
          end
          PH_BUILD: begin
            if (walkLast) begin
              phase <= PH_READY;
              doneQ <= 1'b1;
            end else begin
              walkIdx <= walkIdx + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign busy  = (phase != PH_READY);
  assign ready = (phase == PH_READY);
  assign done  = doneQ;

endmodule

// File: rtl/tdc_cal_dp.sv
module tdc_cal_dp
  import tdc_cal_pkg::*;
#(
  parameter int NUM_BINS  = 64,
  parameter int CNT_W     = 16,
  parameter int HIT_LOG2  = 14,
  parameter int PERIOD_PS = 5000,
  localparam int CODE_W = $clog2(NUM_BINS),
  localparam int TIME_W = $clog2(PERIOD_PS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  calStrobe_t        strobe,
  input  logic [CODE_W-1:0] walkIdx,
  input  logic [CODE_W-1:0] hitCode,
  input  logic              lookupValid,
  input  logic [CODE_W-1:0] lookupAddr,
  input  logic              ready,
  output logic              hitInRange,
  output logic              lookOk,
  output logic [TIME_W-1:0] lookTime
);

  localparam int SUM_W  = CNT_W + CODE_W + 1;
  localparam int PROD_W = SUM_W + TIME_W + HIT_LOG2;
  localparam logic [CNT_W-1:0]  CNT_MAX = '1;
  localparam logic [PROD_W-1:0] PERIOD_W = PROD_W'(PERIOD_PS);

  logic [CNT_W-1:0]  hist [NUM_BINS];
  logic [TIME_W-1:0] tbl  [NUM_BINS];
  logic [SUM_W-1:0]  runSum;
  logic [CNT_W-1:0]  binCnt;
  logic [SUM_W-1:0]  midSum;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] scaled;
  logic [TIME_W-1:0] centre;
  logic              addrInRange;

  assign hitInRange  = int'(hitCode) < NUM_BINS;
  assign addrInRange = int'(lookupAddr) < NUM_BINS;

  // one saturating counter per bin
  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    always_ff @(posedge clk) begin
      if (strobe.clrWr && walkIdx == CODE_W'(b)) begin
        hist[b] <= '0;
      end else if (strobe.hitEn && hitCode == CODE_W'(b) && hist[b] != CNT_MAX) begin
        hist[b] <= hist[b] + 1'b1;
      end
    end
  end

  // centre of the bin under the walk index
  assign binCnt = hist[walkIdx];
  assign midSum = runSum + SUM_W'(binCnt >> 1);
  assign prod   = PROD_W'(midSum) * PERIOD_W;
  assign scaled = prod >> HIT_LOG2;
  assign centre = scaled[TIME_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || strobe.sumClr) begin
      runSum <= '0;
    end else if (strobe.buildWr) begin
      runSum <= runSum + SUM_W'(binCnt);
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.buildWr) begin
      tbl[walkIdx] <= centre;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lookOk   <= 1'b0;
      lookTime <= '0;
    end else begin
      lookOk <= lookupValid && ready;
      if (lookupValid && ready) begin
        lookTime <= addrInRange ? tbl[lookupAddr] : '0;
      end
    end
  end

endmodule

// File: rtl/tdc_code_density_cal.sv
module tdc_code_density_cal
  import tdc_cal_pkg::*;
#(
  parameter int NUM_BINS  = 64,
  parameter int CNT_W     = 16,
  parameter int HIT_LOG2  = 14,
  parameter int PERIOD_PS = 5000,
  localparam int CODE_W = $clog2(NUM_BINS),
  localparam int TIME_W = $clog2(PERIOD_PS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              calStart,
  input  logic              hitValid,
  input  logic [CODE_W-1:0] hitCode,
  input  logic              lookupValid,
  input  logic [CODE_W-1:0] lookupAddr,
  output logic              calBusy,
  output logic              calDone,
  output logic              lookOk,
  output logic [TIME_W-1:0] lookTime
);

  calStrobe_t        strobe;
  logic [CODE_W-1:0] walkIdx;
  logic              hitInRange;
  logic              ready;

  tdc_cal_ctrl #(
    .NUM_BINS(NUM_BINS),
    .HIT_LOG2(HIT_LOG2)
  ) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .startReq  (calStart),
    .hitValid  (hitValid),
    .hitInRange(hitInRange),
    .walkIdx   (walkIdx),
    .strobe    (strobe),
    .busy      (calBusy),
    .done      (calDone),
    .ready     (ready)
  );

  tdc_cal_dp #(
    .NUM_BINS (NUM_BINS),
    .CNT_W    (CNT_W),
    .HIT_LOG2 (HIT_LOG2),
    .PERIOD_PS(PERIOD_PS)
  ) dp_i (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .walkIdx    (walkIdx),
    .hitCode    (hitCode),
    .lookupValid(lookupValid),
    .lookupAddr (lookupAddr),
    .ready      (ready),
    .hitInRange (hitInRange),
    .lookOk     (lookOk),
    .lookTime   (lookTime)
  );

endmodule

// File: rtl/tdc_cal_chk.sv
module tdc_cal_chk (
  input logic clk,
  input logic rst,
  input logic calStart,
  input logic lookupValid,
  input logic calBusy,
  input logic calDone,
  input logic lookOk
);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    calDone |=> !calDone);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    calDone |-> !calBusy);

  // R6
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(calBusy) |-> calDone);

  // R7
  look_after_idle_chk: assert property (@(posedge clk) disable iff (rst)
    lookOk |-> ($past(lookupValid) && !$past(calBusy)));

  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    calStart |=> calBusy);

endmodule

bind tdc_code_density_cal tdc_cal_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .calStart   (calStart),
  .lookupValid(lookupValid),
  .calBusy    (calBusy),
  .calDone    (calDone),
  .lookOk     (lookOk)
);

// File: tb/tdc_code_density_cal_tb.sv
module tdc_code_density_cal_tb_top;

  localparam int NB     = 6;
  localparam int CW     = 5;
  localparam int KL     = 6;
  localparam int PER    = 1000;
  localparam int CODE_W = $clog2(NB);
  localparam int TIME_W = $clog2(PER + 1);
  localparam int CMAX   = (1 << CW) - 1;
  localparam int TOTAL  = 1 << KL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic calStart = 1'b0;
  logic hitValid = 1'b0;
  logic [CODE_W-1:0] hitCode = '0;
  logic lookupValid = 1'b0;
  logic [CODE_W-1:0] lookupAddr = '0;
  logic calBusy, calDone, lookOk;
  logic [TIME_W-1:0] lookTime;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tdc_code_density_cal #(
    .NUM_BINS(NB), .CNT_W(CW), .HIT_LOG2(KL), .PERIOD_PS(PER)
  ) dut_i (
    .clk(clk), .rst(rst), .calStart(calStart), .hitValid(hitValid),
    .hitCode(hitCode), .lookupValid(lookupValid), .lookupAddr(lookupAddr),
    .calBusy(calBusy), .calDone(calDone), .lookOk(lookOk), .lookTime(lookTime)
  );

  // behavioural reference: 0 clear, 1 collect, 2 build, 3 ready
  int     mPhase, mIdx, mHits, mTime;
  int     mHist [NB];
  int     mTable[NB];
  longint mSum;
  bit     mDone, mLv;

  always @(posedge clk) begin
    if (rst) begin
      mPhase = 0; mIdx = 0; mHits = 0; mSum = 0; mDone = 0; mLv = 0; mTime = 0;
    end else begin
      mDone = 0;
      mLv = lookupValid && (mPhase == 3);
      if (mLv) mTime = (int'(lookupAddr) < NB) ? mTable[lookupAddr] : 0;
      if (calStart) begin
        mPhase = 0; mIdx = 0;
      end else begin
        case (mPhase)
          0: begin
            mHist[mIdx] = 0;
            if (mIdx == NB - 1) begin mPhase = 1; mIdx = 0; mHits = 0; end
            else mIdx++;
          end
          1: begin
            mSum = 0;
            if (hitValid && int'(hitCode) < NB) begin
              if (mHist[hitCode] < CMAX) mHist[hitCode]++;
              if (mHits == TOTAL - 1) begin mPhase = 2; mIdx = 0; end
              else mHits++;
            end
          end
          2: begin
            mTable[mIdx] = int'(((mSum + longint'(mHist[mIdx] / 2)) * PER) / TOTAL);
            mSum += mHist[mIdx];
            if (mIdx == NB - 1) begin mPhase = 3; mDone = 1; end
            else mIdx++;
          end
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst && !finished) begin
      checks++;
      if (calBusy !== (mPhase != 3)) begin
        errors++;
        $display("FAIL R1/R6 busy: actual %0b expected %0b", calBusy, (mPhase != 3));
      end
      checks++;
      if (calDone !== mDone) begin
        errors++;
        $display("FAIL R6 done: actual %0b expected %0b", calDone, mDone);
      end
      checks++;
      if (lookOk !== mLv) begin
        errors++;
        $display("FAIL R7 lookOk: actual %0b expected %0b", lookOk, mLv);
      end
      if (mLv) begin
        checks++;
        if (int'(lookTime) != mTime) begin
          errors++;
          $display("FAIL R5 lookTime: actual %0d expected %0d", lookTime, mTime);
        end
      end
    end
  end

  task automatic summary();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cyc);
      summary();
    end
  end

  task automatic waitIdle();
    @(negedge clk);
    while (calBusy) @(negedge clk);
  endtask

  task automatic lookCheck(input int addr, input string tag);
    int exp;
    @(negedge clk);
    lookupValid = 1'b1;
    lookupAddr = CODE_W'(addr);
    exp = (addr < NB) ? mTable[addr] : 0;
    @(negedge clk);
    lookupValid = 1'b0;
    checks++;
    if (!lookOk || int'(lookTime) != exp) begin
      errors++;
      $display("FAIL %s bin %0d: actual ok=%0b time=%0d expected ok=1 time=%0d",
               tag, addr, lookOk, lookTime, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk);
    calStart = 1'b1;
    @(negedge clk);
    calStart = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (calBusy !== 1'b1 || calDone !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: actual busy=%0b done=%0b expected busy=1 done=0", calBusy, calDone);
    end
    rst = 1'b0;

    // R1: hits during the clear walk are ignored
    for (int i = 0; i < 4; i++) begin
      hitValid = 1'b1; hitCode = 3'd1;
      @(negedge clk);
    end

    // R4: flood bin 2 past saturation; R7: lookups while busy
    for (int i = 0; i < 40; i++) begin
      hitValid = 1'b1; hitCode = 3'd2;
      lookupValid = (i % 5 == 0); lookupAddr = 3'd0;
      @(negedge clk);
    end
    lookupValid = 1'b0;
    // R2: cycle through all codes, 6 and 7 out of range; R3: extra hits run into the build
    for (int i = 0; i < 50; i++) begin
      hitValid = 1'b1; hitCode = CODE_W'(i % 8);
      @(negedge clk);
    end
    hitValid = 1'b0;
    waitIdle();
    for (int a = 0; a < 8; a++) lookCheck(a, "R2/R3/R4");

    // R8: restart, then restart again in the middle of collection
    pulseStart();
    checks++;
    if (calBusy !== 1'b1) begin
      errors++;
      $display("FAIL R8 busy after start: actual %0b expected 1", calBusy);
    end
    repeat (NB) @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      hitValid = 1'b1; hitCode = 3'd0;
      @(negedge clk);
    end
    hitValid = 1'b0;
    pulseStart();
    // uneven distribution over in-range bins
    for (int i = 0; i < 90; i++) begin
      hitValid = 1'b1; hitCode = CODE_W'((i * i + i / 3) % NB);
      @(negedge clk);
    end
    hitValid = 1'b0;
    waitIdle();
    for (int a = 0; a < NB; a++) lookCheck(a, "R8/R5");

    // R6: a start while idle rebuilds and pulses done again
    pulseStart();
    for (int i = 0; i < 80; i++) begin
      hitValid = 1'b1; hitCode = CODE_W'(5 - (i % 3));
      @(negedge clk);
    end
    hitValid = 1'b0;
    waitIdle();
    for (int a = 0; a < NB; a++) lookCheck(a, "R6/R5");

    repeat (4) @(negedge clk);
    summary();
  end

endmodule